// File: doc/BRIEF.md
# Byte-Serial Pixel Assembler

This block sits between an 8-bit parallel video port and the 18-bit pixel input of a TFT panel. It collects a run of bytes and rebuilds one full pixel from them. A pixel-valid strobe marks each finished pixel. An elaboration parameter picks the wire format. In the 16-bit colour format a pixel is two bytes, and in the 24-bit colour format a pixel is three bytes. When no format is chosen, the 16-bit format applies.

A line-start input marks the first byte of each active line. It forces the byte counter back to the first byte of a pixel, so a dropped or extra byte cannot carry a colour shift into the next line. The delay from the first byte of a pixel to its strobe is fixed for each format. The upstream sync generator pushes its first active pixel later by that amount. The output word stays at its value until the next strobe.

Top module: `byte_pixel_assembler`

## Requirements
- R1: While reset is held, and right after it is released, `pix_vld` is 0 and `pix_rgb` is all zeros.
- R2: In 16-bit format (FORMAT = FMT_RGB565) the first byte of a pixel is the high half of word W = {byte0, byte1}. The fields are red W[15:11], green W[10:5] and blue W[4:0]. The output is `pix_rgb` = {R5, R5[4], G6, B5, B5[4]}, with red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R3: In 24-bit format (FORMAT = FMT_RGB888) bytes arrive red, then green, then blue. `pix_rgb` = {red[7:2], green[7:2], blue[7:2]}.
- R4: When a pixel's bytes arrive on consecutive clocks, `pix_vld` is high in the 3rd clock after the clock carrying the first byte in 16-bit format, and in the 5th clock after it in 24-bit format.
- R5: `pix_vld` is high for exactly one clock per assembled pixel. Pixels sent back to back give strobes spaced by the bytes-per-pixel count.
- R6: `pix_rgb` changes only in a clock where `pix_vld` is high, and otherwise keeps the last pixel.
- R7: A byte presented with `line_start` high is taken as byte 0 of a new pixel. A partly received pixel is dropped and produces no strobe.
- R8: Clocks with `byte_vld` low are ignored: the byte position does not advance and no strobe results. A gap inside a pixel delays its strobe by the gap length.
- R9: With the format parameter left at its default, the block behaves as the 16-bit format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_in | input | 8 | Incoming byte |
| byte_vld | input | 1 | `byte_in` carries a byte this clock |
| line_start | input | 1 | This clock begins a line's active window (realigns to byte 0) |
| pix_rgb | output | 18 | Assembled pixel {red6, green6, blue6} |
| pix_vld | output | 1 | One-clock strobe per new pixel |

## Verification
Every result is due on a clock fixed by counting from the clock that carried a pixel's first byte. The strobe is due 3 clocks later in 16-bit format and 5 clocks later in 24-bit format, plus one clock for each idle gap inside the pixel. The bench drives bytes on the falling edge and samples on falling edges at exactly that offset. It also samples the clock just before the due clock, to confirm the strobe is still low, and the clock just after, to confirm the strobe has dropped and the word is held. The realignment tests sample at the clock where a misaligned strobe would have appeared, so a counter that ignores `line_start` shows up as an early strobe.

// File: rtl/bpa_pkg.sv
// Shared definitions for the byte-serial pixel assembler.
// Assumes: one 8-bit byte per clock on the input side, an 18-bit RGB bus on the output side.
package bpa_pkg;

    localparam int BYTE_W = 8;
    localparam int CH_W   = 6;
    localparam int PIX_W  = 3 * CH_W;

    typedef enum logic {
        FMT_RGB565 = 1'b0,
        FMT_RGB888 = 1'b1
    } pix_fmt_e;

    // Bytes that make up one pixel in the selected format.
    function automatic int bytes_per_pix(pix_fmt_e f);
        return (f == FMT_RGB888) ? 3 : 2;
    endfunction

    // Clocks from the first byte of a pixel to its output strobe.
    function automatic int pipe_latency(pix_fmt_e f);
        return (f == FMT_RGB888) ? 5 : 3;
    endfunction

endpackage

// File: rtl/bpa_phase.sv
// Byte position counter.
// Tracks which byte of the current pixel is on the input. Line start forces position 0
// for the byte in the same clock. Idle clocks leave the position alone.
// Assumes: BPP >= 2 and PH_W = $clog2(BPP).
module bpa_phase #(
    parameter int BPP  = 2,
    parameter int PH_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_vld,
    input  logic            line_start,
    output logic [PH_W-1:0] phase,
    output logic            last
);

    logic [PH_W-1:0] ph_q;

    // Effective position of this clock's byte, and whether it completes a pixel.
    always_comb begin
        phase = line_start ? '0 : ph_q;
        last  = byte_vld && (phase == PH_W'(BPP - 1));
    end

    // Advance on each valid byte; wrap after the final byte; realign on line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (byte_vld) begin
            ph_q <= last ? '0 : phase + PH_W'(1);
        end else if (line_start) begin
            ph_q <= '0;
        end
    end

    AST_LINE_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && byte_vld) |=> (ph_q == PH_W'(1))); // R7

    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !line_start) |=> $stable(ph_q)); // R8

endmodule

// File: rtl/bpa_pack.sv
// Byte packer and colour widener.
// Keeps the leading bytes of a pixel. When the last byte arrives, it combines them with
// that byte into an 18-bit word and registers the word with a one-clock valid.
// Assumes: phase/last come from bpa_phase with the same BPP.
module bpa_pack #(
    parameter bpa_pkg::pix_fmt_e FORMAT = bpa_pkg::FMT_RGB565,
    parameter int BPP  = 2,
    parameter int PH_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [bpa_pkg::BYTE_W-1:0] byte_in,
    input  logic                       byte_vld,
    input  logic [PH_W-1:0]            phase,
    input  logic                       last,
    output logic [bpa_pkg::PIX_W-1:0]  asm_rgb,
    output logic                       asm_vld
);

    logic [BPP-2:0][bpa_pkg::BYTE_W-1:0] held_q;
    logic [bpa_pkg::PIX_W-1:0]           rgb_nxt;

    // One holding register for each leading byte position.
    for (genvar g = 0; g < BPP - 1; g++) begin : g_hold
        // Capture the byte whose position matches this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[g] <= '0;
            end else if (byte_vld && (phase == PH_W'(g))) begin
                held_q[g] <= byte_in;
            end
        end
    end

    // Format-specific unpacking into 6-bit channels.
    if (FORMAT == bpa_pkg::FMT_RGB565) begin : g_fmt565
        logic [15:0] word;
        // High byte first; 5-bit fields widened by repeating their MSB.
        always_comb begin
            word    = {held_q[0], byte_in};
            rgb_nxt = {word[15:11], word[15], word[10:5], word[4:0], word[4]};
        end

        AST_MSB_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
            asm_vld |-> (asm_rgb[12] == asm_rgb[17]) && (asm_rgb[0] == asm_rgb[5])); // R2
    end else begin : g_fmt888
        // Red, green, blue order; keep the top six bits of each.
        always_comb begin
            rgb_nxt = {held_q[0][7:2], held_q[1][7:2], byte_in[7:2]};
        end
    end

    // Register the finished pixel and its one-clock valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_rgb <= '0;
            asm_vld <= 1'b0;
        end else begin
            asm_vld <= last;
            if (last) begin
                asm_rgb <= rgb_nxt;
            end
        end
    end

    AST_ASM_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        asm_vld |-> $past(byte_vld)); // R8

endmodule

// File: rtl/bpa_delay.sv
// Latency padding pipeline.
// Adds PAD register stages, so the block's total latency matches the format's fixed
// figure. Each data stage loads only when its input is valid, so the last stage holds
// the most recent pixel between strobes.
// Assumes: PAD >= 1.
module bpa_delay #(
    parameter int PAD = 1,
    parameter int W   = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    logic [PAD-1:0]        vld_q;
    logic [PAD-1:0][W-1:0] dat_q;

    for (genvar s = 0; s < PAD; s++) begin : g_stage
        logic         src_vld;
        logic [W-1:0] src_dat;

        // Select this stage's source: block input or the previous stage.
        always_comb begin
            if (s == 0) begin
                src_vld = in_vld;
                src_dat = in_data;
            end else begin
                src_vld = vld_q[(s == 0) ? 0 : s - 1];
                src_dat = dat_q[(s == 0) ? 0 : s - 1];
            end
        end

        // Shift the valid; load data only alongside a valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else begin
                vld_q[s] <= src_vld;
                if (src_vld) begin
                    dat_q[s] <= src_dat;
                end
            end
        end
    end

    // Drive the outputs from the final stage.
    always_comb begin
        out_vld  = vld_q[PAD-1];
        out_data = dat_q[PAD-1];
    end

    AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, PAD)); // R4

endmodule

// File: rtl/byte_pixel_assembler.sv
// Byte-serial to parallel pixel assembler (top level).
// Counts byte positions, packs and widens each pixel to 18 bits, and pads the result
// to the format's fixed latency: 3 clocks for 16-bit colour, 5 for 24-bit colour.
// Assumes: bytes of one pixel normally arrive on consecutive clocks, and line_start
// is raised with the first byte of each active line.
module byte_pixel_assembler #(
    parameter bpa_pkg::pix_fmt_e FORMAT = bpa_pkg::FMT_RGB565
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  byte_in,
    input  logic        byte_vld,
    input  logic        line_start,
    output logic [17:0] pix_rgb,
    output logic        pix_vld
);

    localparam int BPP  = bpa_pkg::bytes_per_pix(FORMAT);
    localparam int LAT  = bpa_pkg::pipe_latency(FORMAT);
    localparam int PAD  = LAT - BPP;
    localparam int PH_W = $clog2(BPP);

    logic [PH_W-1:0]              phase;
    logic                         last;
    logic [bpa_pkg::PIX_W-1:0]    asm_rgb;
    logic                         asm_vld;

    bpa_phase #(.BPP(BPP), .PH_W(PH_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .line_start (line_start),
        .phase      (phase),
        .last       (last)
    );

    bpa_pack #(.FORMAT(FORMAT), .BPP(BPP), .PH_W(PH_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (byte_in),
        .byte_vld (byte_vld),
        .phase    (phase),
        .last     (last),
        .asm_rgb  (asm_rgb),
        .asm_vld  (asm_vld)
    );

    bpa_delay #(.PAD(PAD), .W(bpa_pkg::PIX_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (asm_vld),
        .in_data  (asm_rgb),
        .out_vld  (pix_vld),
        .out_data (pix_rgb)
    );

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> !pix_vld); // R5

    AST_HOLD_RGB: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> $stable(pix_rgb)); // R6

endmodule

// File: tb/byte_pixel_assembler_test.sv
`timescale 1ns/1ps
module byte_pixel_assembler_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // 16-bit format unit (default parameter, R9)
    logic [7:0]  a_byte = '0;
    logic        a_vld = 1'b0, a_ls = 1'b0;
    logic [17:0] a_rgb;
    logic        a_pvld;
    // 24-bit format unit
    logic [7:0]  b_byte = '0;
    logic        b_vld = 1'b0, b_ls = 1'b0;
    logic [17:0] b_rgb;
    logic        b_pvld;

    byte_pixel_assembler uut (
        .clk(clk), .rst_n(rst_n), .byte_in(a_byte), .byte_vld(a_vld),
        .line_start(a_ls), .pix_rgb(a_rgb), .pix_vld(a_pvld)
    );

    byte_pixel_assembler #(.FORMAT(bpa_pkg::FMT_RGB888)) uut_rgb888 (
        .clk(clk), .rst_n(rst_n), .byte_in(b_byte), .byte_vld(b_vld),
        .line_start(b_ls), .pix_rgb(b_rgb), .pix_vld(b_pvld)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct packed {
        logic        fmt;
        logic [23:0] din;
        logic [17:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 24'h00FFFF, 18'h3FFFF},
        '{1'b0, 24'h000000, 18'h00000},
        '{1'b0, 24'h00F800, 18'h3F000},
        '{1'b0, 24'h0007E0, 18'h00FC0},
        '{1'b0, 24'h00001F, 18'h0003F},
        '{1'b0, 24'h008410, 18'h21821},
        '{1'b1, 24'hFFFFFF, 18'h3FFFF},
        '{1'b1, 24'h123456, 18'h04355},
        '{1'b1, 24'hFC0003, 18'h3F000},
        '{1'b1, 24'h03FF03, 18'h00FC0}
    };

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // 16-bit format: bytes on t0,t1; strobe due at t3 (R4)
    task automatic run565(input logic [15:0] w, input logic [17:0] exp);
        @(negedge clk); a_byte = w[15:8]; a_vld = 1'b1; a_ls = 1'b1;
        @(negedge clk); a_byte = w[7:0];  a_ls = 1'b0;
        @(negedge clk); a_vld = 1'b0; a_byte = 8'h5A;
        chk("R4 early 565", 18'(a_pvld), 18'h0);
        @(negedge clk);
        chk("R4 strobe 565", 18'(a_pvld), 18'h1);
        chk("R2 R9 pixel 565", a_rgb, exp);
        @(negedge clk);
        chk("R5 single 565", 18'(a_pvld), 18'h0);
        chk("R6 hold 565", a_rgb, exp);
    endtask

    // 24-bit format: bytes on t0..t2; strobe due at t5 (R4)
    task automatic run888(input logic [23:0] d, input logic [17:0] exp);
        @(negedge clk); b_byte = d[23:16]; b_vld = 1'b1; b_ls = 1'b1;
        @(negedge clk); b_byte = d[15:8];  b_ls = 1'b0;
        @(negedge clk); b_byte = d[7:0];
        @(negedge clk); b_vld = 1'b0; b_byte = 8'hA5;
        @(negedge clk);
        chk("R4 early 888", 18'(b_pvld), 18'h0);
        @(negedge clk);
        chk("R4 strobe 888", 18'(b_pvld), 18'h1);
        chk("R3 pixel 888", b_rgb, exp);
        @(negedge clk);
        chk("R5 single 888", 18'(b_pvld), 18'h0);
        chk("R6 hold 888", b_rgb, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held and after release
        chk("R1 vld in reset", 18'({a_pvld, b_pvld}), 18'h0);
        chk("R1 rgb in reset 565", a_rgb, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld after reset", 18'({a_pvld, b_pvld}), 18'h0);
        chk("R1 rgb after reset 888", b_rgb, 18'h0);

        // Vector table walk
        for (int i = 0; i < 10; i++) begin
            if (VECS[i].fmt == 1'b0) run565(VECS[i].din[15:0], VECS[i].exp);
            else                     run888(VECS[i].din, VECS[i].exp);
        end

        // R5: back-to-back 16-bit pixels, strobes at t3 and t5
        @(negedge clk); a_byte = 8'hF8; a_vld = 1'b1; a_ls = 1'b1;
        @(negedge clk); a_byte = 8'h00; a_ls = 1'b0;
        @(negedge clk); a_byte = 8'h00;
        @(negedge clk); a_byte = 8'h1F;
        chk("R5 b2b first strobe", 18'(a_pvld), 18'h1);
        chk("R5 b2b first pixel", a_rgb, 18'h3F000);
        @(negedge clk); a_vld = 1'b0;
        chk("R5 b2b gap low", 18'(a_pvld), 18'h0);
        @(negedge clk);
        chk("R5 b2b second strobe", 18'(a_pvld), 18'h1);
        chk("R5 b2b second pixel", a_rgb, 18'h0003F);
        repeat (2) @(negedge clk);

        // R7: stray byte then line start; misaligned strobe would be at t3
        @(negedge clk); a_byte = 8'hFF; a_vld = 1'b1; a_ls = 1'b1;
        @(negedge clk); a_byte = 8'hF8;
        @(negedge clk); a_byte = 8'h00; a_ls = 1'b0;
        @(negedge clk); a_vld = 1'b0;
        chk("R7 no partial strobe 565", 18'(a_pvld), 18'h0);
        @(negedge clk);
        chk("R7 realigned strobe 565", 18'(a_pvld), 18'h1);
        chk("R7 realigned pixel 565", a_rgb, 18'h3F000);
        repeat (2) @(negedge clk);

        // R7: two stray bytes then line start on 24-bit unit
        @(negedge clk); b_byte = 8'h11; b_vld = 1'b1; b_ls = 1'b1;
        @(negedge clk); b_byte = 8'h22; b_ls = 1'b0;
        @(negedge clk); b_byte = 8'hFC; b_ls = 1'b1;
        @(negedge clk); b_byte = 8'h00; b_ls = 1'b0;
        @(negedge clk); b_byte = 8'h03;
        @(negedge clk); b_vld = 1'b0;
        chk("R7 no partial strobe 888", 18'(b_pvld), 18'h0);
        @(negedge clk);
        chk("R7 still waiting 888", 18'(b_pvld), 18'h0);
        @(negedge clk);
        chk("R7 realigned strobe 888", 18'(b_pvld), 18'h1);
        chk("R7 realigned pixel 888", b_rgb, 18'h3F000);
        repeat (2) @(negedge clk);

        // R8: one idle clock inside a 16-bit pixel delays strobe to t4
        @(negedge clk); a_byte = 8'h07; a_vld = 1'b1; a_ls = 1'b1;
        @(negedge clk); a_byte = 8'hAA; a_vld = 1'b0; a_ls = 1'b0;
        @(negedge clk); a_byte = 8'hE0; a_vld = 1'b1;
        @(negedge clk); a_vld = 1'b0;
        chk("R8 gap delays strobe 565", 18'(a_pvld), 18'h0);
        @(negedge clk);
        chk("R8 strobe after gap 565", 18'(a_pvld), 18'h1);
        chk("R8 pixel after gap 565", a_rgb, 18'h00FC0);
        repeat (2) @(negedge clk);

        // R8: idle clock inside a 24-bit pixel, strobe at t6
        @(negedge clk); b_byte = 8'h12; b_vld = 1'b1; b_ls = 1'b1;
        @(negedge clk); b_byte = 8'h34; b_ls = 1'b0;
        @(negedge clk); b_byte = 8'hFF; b_vld = 1'b0;
        @(negedge clk); b_byte = 8'h56; b_vld = 1'b1;
        @(negedge clk); b_vld = 1'b0;
        @(negedge clk);
        chk("R8 gap delays strobe 888", 18'(b_pvld), 18'h0);
        @(negedge clk);
        chk("R8 strobe after gap 888", 18'(b_pvld), 18'h1);
        chk("R8 pixel after gap 888", b_rgb, 18'h04355);
        repeat (2) @(negedge clk);

        // R8/R6: garbage with byte_vld low changes nothing
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); a_byte = 8'(k * 37 + 3); b_byte = 8'(k * 91 + 7);
            chk("R8 idle no strobe", 18'({a_pvld, b_pvld}), 18'h0);
            chk("R6 idle hold 565", a_rgb, 18'h00FC0);
            chk("R6 idle hold 888", b_rgb, 18'h04355);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule